// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block collects interrupt requests from on-chip peripherals into a pending-flag register and gates them with an enable register, both reachable over a simple register bus. A request pulse on one input line latches the matching flag. Software acknowledges a source by writing a zero into that flag's position; ones written to the pending register leave flags as they are, so one write can retire any chosen subset of sources without a read-modify-write.

The single CPU interrupt line is driven from a register and goes high whenever at least one pending flag is also enabled. Both registers accept 16-bit and 32-bit accesses. Only the low source bits are implemented, and everything above them reads as zero. By convention, source line 3 carries the DMA engine, line 7 the serial port and line 9 the sound unit, though the block treats every line the same way.

Top module: `irqc_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the pending flags, the enable mask and `irq_o` are all cleared to zero.
- R2: A high bit on `req_i` at a rising edge sets the pending flag of the same bit position (bit i of `req_i` maps to flag i). The flag then stays set until it is acknowledged.
- R3: A write to the pending register (byte offset 0x70) replaces the flags with the bitwise AND of the old flags and the written data. A 0 bit clears its flag and a 1 bit leaves it unchanged.
- R4: When a request and an acknowledging write hit the same flag at the same edge, the flag is set after that edge.
- R5: A write to the mask register (byte offset 0x74) stores the written bits directly. They read back from the cycle after the write.
- R6: `irq_o` is high in the cycle after any cycle in which (flags AND mask) is nonzero, and low otherwise. A mask write at edge E therefore shows on `irq_o` after edge E+1.
- R7: Bits at and above position NUM_SRC (default 11) always read as zero and are not stored on writes.
- R8: `bus_size` = 1 selects a 32-bit access, and `bus_size` = 0 selects a 16-bit access. A 16-bit access at offset +0 covers bits 15:0 and one at offset +2 covers bits 31:16, with its data on `bus_wdata[15:0]` and `bus_rdata[15:0]` and `bus_rdata[31:16]` held at zero. A 16-bit write to the upper half changes no implemented bit.
- R9: A read of any offset other than the two registers returns zero, and a write to such an offset changes neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NUM_SRC | Request pulses from the sources, one bit per source |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_size | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| irq_o | output | 1 | Registered interrupt line to the CPU |

## Verification
Two functions can fall in the same cycle: a source can raise its request in the very cycle that software writes a zero to acknowledge that same flag, and a mask write can coincide with flags that are already pending. The stimulus table contains a vector that writes an all-zero acknowledge to the pending register while the sound-source request is held high. That case is judged by reading the flag back as still set and by seeing the interrupt line stay high. A separate directed test writes the mask while a flag is pending and samples `irq_o` after the write edge and again one edge later, expecting low and then high.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg
// Shared constants and types for the interrupt status/mask controller.
// Assumes a 32-bit register bus made of two 16-bit lanes.
package irqc_pkg;
    localparam int BUS_W  = 32;
    localparam int HALF_W = 16;
    localparam int LANES  = BUS_W / HALF_W;

    // Conventional source positions used by the surrounding chip
    localparam int SRC_DMA    = 3;
    localparam int SRC_SERIAL = 7;
    localparam int SRC_SOUND  = 9;

    typedef enum logic {
        SZ_HALF = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;

    typedef struct packed {
        logic              st_wr;    // write hits pending register
        logic              mk_wr;    // write hits mask register
        logic [LANES-1:0]  lane_en;  // 16-bit lanes touched
        logic [BUS_W-1:0]  data;     // write data aligned to lanes
    } wr_cmd_t;
endpackage

// File: rtl/irqc_decode.sv
// Module irqc_decode
// Decodes bus offsets into register write commands and selects read data.
// Assumes accesses are naturally aligned; misaligned ones hit nothing.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int              ADDR_W = 8,
    parameter logic [ADDR_W-1:0] ST_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MK_OFS = 8'h74
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_size,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [BUS_W-1:0]  st_view,
    input  logic [BUS_W-1:0]  mk_view,
    output wr_cmd_t           cmd,
    output logic [BUS_W-1:0]  bus_rdata
);
    logic              aligned;
    logic [ADDR_W-1:0] word_addr;
    logic              st_hit;
    logic              mk_hit;
    logic [BUS_W-1:0]  sel_view;

    // Address match on the word base, with alignment per access size
    always_comb begin
        aligned   = (bus_size == SZ_WORD) ? (bus_addr[1:0] == 2'b00) : (bus_addr[0] == 1'b0);
        word_addr = {bus_addr[ADDR_W-1:2], 2'b00};
        st_hit    = aligned && (word_addr == ST_OFS);
        mk_hit    = aligned && (word_addr == MK_OFS);
    end

    // Build the write command with lane enables and lane-replicated data
    always_comb begin
        cmd.st_wr = bus_wr && st_hit;
        cmd.mk_wr = bus_wr && mk_hit;
        if (bus_size == SZ_WORD) begin
            cmd.lane_en = '1;
            cmd.data    = bus_wdata;
        end else begin
            cmd.lane_en = bus_addr[1] ? 2'b10 : 2'b01;
            cmd.data    = {bus_wdata[HALF_W-1:0], bus_wdata[HALF_W-1:0]};
        end
    end

    // Read mux: register view, then half-word steering for 16-bit reads
    always_comb begin
        sel_view = st_hit ? st_view : (mk_hit ? mk_view : '0);
        if (bus_size == SZ_WORD)
            bus_rdata = sel_view;
        else
            bus_rdata = {{HALF_W{1'b0}}, (bus_addr[1] ? sel_view[BUS_W-1:HALF_W] : sel_view[HALF_W-1:0])};
    end
endmodule

// File: rtl/irqc_status.sv
// Module irqc_status
// Pending-flag register: requests set flags, writes AND data into flags.
// Assumes NUM_SRC <= 32; a request beats an acknowledge in the same cycle.
module irqc_status
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               wr_en,
    input  logic [LANES-1:0]   lane_en,
    input  logic [BUS_W-1:0]   wdata,
    output logic [NUM_SRC-1:0] flags_q
);
    logic [NUM_SRC-1:0] keep;
    logic [NUM_SRC-1:0] flags_d;

    // Per-bit keep mask: untouched lanes behave as written ones
    always_comb begin
        for (int b = 0; b < NUM_SRC; b++)
            keep[b] = lane_en[b / HALF_W] ? wdata[b] : 1'b1;
    end

    // Next flags: acknowledge first, then merge new requests
    always_comb begin
        flags_d = wr_en ? (flags_q & keep) : flags_q;
        flags_d = flags_d | req_i;
    end

    // Flag register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    // R2 R4
    req_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((flags_q & $past(req_i)) == $past(req_i)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags_q & ~$past(flags_q) & ~$past(req_i)) == '0));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && req_i == '0) |=> $stable(flags_q));
endmodule

// File: rtl/irqc_mask.sv
// Module irqc_mask
// Enable-mask register: written lanes replace stored bits directly.
// Assumes NUM_SRC <= 32; bits above NUM_SRC are not stored.
module irqc_mask
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LANES-1:0]   lane_en,
    input  logic [BUS_W-1:0]   wdata,
    output logic [NUM_SRC-1:0] mask_q
);
    logic [NUM_SRC-1:0] mask_d;

    // Per-bit replace for written lanes, hold for the others
    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            for (int b = 0; b < NUM_SRC; b++)
                if (lane_en[b / HALF_W]) mask_d[b] = wdata[b];
        end
    end

    // Mask register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irqc_ctrl.sv
// Module irqc_ctrl
// Top of the interrupt controller: decode, pending flags, mask, and the
// registered CPU interrupt line. Assumes one access per cycle.
module irqc_ctrl
    import irqc_pkg::*;
#(
    parameter int              NUM_SRC = 11,
    parameter int              ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ST_OFS = 8'h70,
    parameter logic [ADDR_W-1:0] MK_OFS = 8'h74
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_size,
    input  logic [BUS_W-1:0]   bus_wdata,
    output logic [BUS_W-1:0]   bus_rdata,
    output logic               irq_o
);
    wr_cmd_t            cmd;
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [BUS_W-1:0]   st_view;
    logic [BUS_W-1:0]   mk_view;
    logic               irq_q;

    // Zero-extend both registers to bus width for the read mux
    always_comb begin
        st_view = '0;
        mk_view = '0;
        st_view[NUM_SRC-1:0] = flags_q;
        mk_view[NUM_SRC-1:0] = mask_q;
    end

    irqc_decode #(.ADDR_W(ADDR_W), .ST_OFS(ST_OFS), .MK_OFS(MK_OFS)) u_decode (
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .st_view  (st_view),
        .mk_view  (mk_view),
        .cmd      (cmd),
        .bus_rdata(bus_rdata)
    );

    irqc_status #(.NUM_SRC(NUM_SRC)) u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_i  (req_i),
        .wr_en  (cmd.st_wr),
        .lane_en(cmd.lane_en),
        .wdata  (cmd.data),
        .flags_q(flags_q)
    );

    irqc_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cmd.mk_wr),
        .lane_en(cmd.lane_en),
        .wdata  (cmd.data),
        .mask_q (mask_q)
    );

    // Registered interrupt line from the enabled pending flags
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(flags_q & mask_q);
    end

    assign irq_o = irq_q;

    // R6
    irq_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == |($past(flags_q) & $past(mask_q))));

    // R7
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[BUS_W-1:NUM_SRC] == '0);

    // R9
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !cmd.st_wr && !cmd.mk_wr && req_i == '0) |=> ($stable(flags_q) && $stable(mask_q)));
endmodule

// File: tb/irqc_ctrl_bench.sv
// Bench irqc_ctrl_bench
// Walks a vector table of bus/request stimuli with expected register
// contents, then runs directed checks for reset, timing and read steering.
module irqc_ctrl_bench;
    localparam int CLK_P   = 10;
    localparam int NSRC    = 11;
    localparam int NVEC    = 15;

    typedef struct packed {
        logic        wr;
        logic [7:0]  addr;
        logic        sz;
        logic [31:0] wd;
        logic [10:0] rq;
        logic [10:0] es;
        logic [10:0] em;
        logic        ei;
    } vec_t;

    // wr, addr, size, wdata, req, expected flags, expected mask, expected irq
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h70, 1'b1, 32'h0000_0000, 11'h008, 11'h008, 11'h000, 1'b0}, // R2 DMA
        '{1'b0, 8'h70, 1'b1, 32'h0000_0000, 11'h080, 11'h088, 11'h000, 1'b0}, // R2 serial
        '{1'b1, 8'h74, 1'b1, 32'h0000_0008, 11'h000, 11'h088, 11'h008, 1'b1}, // R5 R6
        '{1'b1, 8'h70, 1'b1, 32'hFFFF_FFF7, 11'h000, 11'h080, 11'h008, 1'b0}, // R3 ack bit 3
        '{1'b1, 8'h74, 1'b0, 32'h0000_0280, 11'h000, 11'h080, 11'h280, 1'b1}, // R8 16-bit mask
        '{1'b0, 8'h70, 1'b1, 32'h0000_0000, 11'h200, 11'h280, 11'h280, 1'b1}, // R2 sound
        '{1'b1, 8'h70, 1'b0, 32'h0000_FF7F, 11'h000, 11'h200, 11'h280, 1'b1}, // R3 R8 16-bit ack
        '{1'b1, 8'h72, 1'b0, 32'h0000_0000, 11'h000, 11'h200, 11'h280, 1'b1}, // R8 upper-half ack
        '{1'b1, 8'h76, 1'b0, 32'h0000_FFFF, 11'h000, 11'h200, 11'h280, 1'b1}, // R7 R8 upper-half mask
        '{1'b1, 8'h70, 1'b1, 32'h0000_0000, 11'h200, 11'h200, 11'h280, 1'b1}, // R4 collision
        '{1'b1, 8'h74, 1'b1, 32'hFFFF_FFFF, 11'h000, 11'h200, 11'h7FF, 1'b1}, // R7 mask
        '{1'b1, 8'h70, 1'b1, 32'h0000_0000, 11'h000, 11'h000, 11'h7FF, 1'b0}, // R3 clear all
        '{1'b1, 8'h60, 1'b1, 32'h0000_0000, 11'h000, 11'h000, 11'h7FF, 1'b0}, // R9 foreign write
        '{1'b0, 8'h70, 1'b1, 32'h0000_0000, 11'h7FF, 11'h7FF, 11'h7FF, 1'b1}, // R2 all sources
        '{1'b1, 8'h70, 1'b1, 32'hFFFF_F800, 11'h000, 11'h000, 11'h7FF, 1'b0}  // R3 R7 upper ones
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] req_i = '0;
    logic [7:0]      bus_addr = 8'h70;
    logic            bus_wr = 1'b0;
    logic            bus_size = 1'b1;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            irq_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    irqc_ctrl u_irqc_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_i    (req_i),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_size (bus_size),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_o    (irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // Read a register at the current cycle (inputs idle), combinational path
    task automatic rd(input logic [7:0] a, input logic sz, output logic [31:0] v);
        bus_wr = 1'b0; bus_addr = a; bus_size = sz;
        #1 v = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(8'h70, 1'b1, v); chk("R1 flags after reset", v, 32'h0);
        rd(8'h74, 1'b1, v); chk("R1 mask after reset", v, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // table walk: one stimulus cycle, readback, irq one edge later
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bus_wr = VECS[i].wr; bus_addr = VECS[i].addr; bus_size = VECS[i].sz;
            bus_wdata = VECS[i].wd; req_i = VECS[i].rq;
            @(negedge clk);
            req_i = '0;
            rd(8'h70, 1'b1, v); chk($sformatf("vec%0d flags R2 R3 R4 R7", i), v, {21'b0, VECS[i].es});
            rd(8'h74, 1'b1, v); chk($sformatf("vec%0d mask R5 R7 R8 R9", i), v, {21'b0, VECS[i].em});
            @(negedge clk); #1;
            chk($sformatf("vec%0d irq R6", i), {31'b0, irq_o}, {31'b0, VECS[i].ei});
        end

        // R6 timing: pending flag, mask written, irq rises one edge later
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'h74; bus_size = 1'b1; bus_wdata = 32'h0; req_i = 11'h080;
        @(negedge clk);
        req_i = '0; bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_wr = 1'b0; #1;
        chk("R6 irq low right after mask write", {31'b0, irq_o}, 32'h0);
        @(negedge clk); #1;
        chk("R6 irq high one edge later", {31'b0, irq_o}, 32'h1);

        // R8 16-bit read steering, R9 unmapped read
        rd(8'h70, 1'b0, v); chk("R8 16-bit low half of flags", v, 32'h0000_0080);
        rd(8'h72, 1'b0, v); chk("R8 16-bit upper half of flags", v, 32'h0);
        rd(8'h74, 1'b0, v); chk("R8 16-bit low half of mask", v, 32'h0000_0080);
        rd(8'h60, 1'b1, v); chk("R9 unmapped read", v, 32'h0);

        // R1 reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        rd(8'h70, 1'b1, v); chk("R1 flags cleared by reset", v, 32'h0);
        rd(8'h74, 1'b1, v); chk("R1 mask cleared by reset", v, 32'h0);
        chk("R1 irq cleared by reset", {31'b0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired got running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule